// File: doc/BRIEF.md
# Stereo Serial Audio Transmit Port

This block is a transmit-only I2S master that sends stereo PCM to an external DAC. It produces four pins: a master clock, a bit clock, a word-select line and a serial data line. The master clock is either the system clock itself or half of it. The half-rate option is meant for a system clock of about twice the nominal 12.288 MHz. The sample rate is set only by the ratio between the bit clock and the master clock. The master clock frequency does not change with the rate.

Sample pairs arrive over a valid/ready handshake into a one-deep holding slot. Each frame is 32 bit clocks long and carries 16 bits per channel. A new pair is taken at the start of every frame. When no new pair is waiting, the last pair is sent again.

A 4-bit configuration register sets the enable, the master-clock gate and the rate. The port enable, the rate and the clock-range bit take effect only at frame boundaries. While the port is off, the four pins carry a general-purpose output value and output-enable supplied from outside.

Top module: `i2s_dac_port`

## Requirements
- R1: After reset, `cfg_q` is 0, the pins are in general-purpose mode, and `smp_ready` is 1.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` appears on `cfg_q` after that edge. Field layout: bit 3 gates the master clock, bit 2 enables the port, bits 1:0 select the rate.
- R3: While the port is inactive, `pad_out` equals `gpio_out` and `pad_oe` equals `gpio_oe`. While it is active, `pad_oe` is 4'hF. The pin order is bit 0 master clock, bit 1 bit clock, bit 2 word select, bit 3 data.
- R4: When cfg bit 3 is 0, the master-clock pin stays low. When bit 3 is 1 and `clk_range` is 0, the pin follows `clk`. When bit 3 is 1 and `clk_range` is 1, the pin toggles on every `clk` edge, which gives half the frequency.
- R5: The bit-clock period in `clk` cycles is 8 for rate 00 or 11, 4 for rate 01 and 2 for rate 10. Each of these doubles when `clk_range` is 1. This is master clock /8, /4 and /2.
- R6: A frame is 32 bit clocks long. Word select is low for 16 bit clocks, then high for 16. It changes one bit clock before each word's MSB. Data changes on falling bit-clock edges, so the receiver samples on rising edges. The left word is sent first, then the right word, each MSB first.
- R7: `smp_ready` is high whenever the holding slot is empty. A pair accepted at a clock edge is sent in the first frame whose boundary (the falling bit-clock edge that begins slot 0) falls at that edge or later. A pair accepted exactly at a boundary is sent in the frame that starts there.
- R8: A frame that starts with no new pair available repeats the previously sent pair.
- R9: Changes to the port enable, the rate bits or `clk_range` are applied only at a frame boundary, so every frame is complete and uses one bit-clock period throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the master-clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_range | input | 1 | 1 when clk is about twice the nominal master clock |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write value |
| cfg_q | output | 4 | Current configuration value |
| smp_valid | input | 1 | Sample pair offered |
| smp_left | input | 16 | Left-channel sample |
| smp_right | input | 16 | Right-channel sample |
| smp_ready | output | 1 | Holding slot empty; pair accepted when both valid and ready |
| gpio_out | input | 4 | Pin values while the port is inactive |
| gpio_oe | input | 4 | Pin output enables while the port is inactive |
| pad_out | output | 4 | Pin values {data, word select, bit clock, master clock} |
| pad_oe | output | 4 | Pin output enables |

## Verification
A pair can be accepted on the same clock edge where a frame boundary loads the serializer. The design then has to decide whether that pair goes out at once or waits a full frame. The bench provokes this case by timing one-cycle valid pulses from three cycles before a predicted boundary to two cycles after it. It predicts the boundary from the observed rising bit-clock edge at slot 0. Each pulse is judged by the decoded frames: every frame that starts before the acceptance edge must still carry the previous pair, and the frame that starts at or after that edge must carry the new one.

// File: rtl/i2s_dac_pkg.sv
package i2s_dac_pkg;

  localparam int CFG_W  = 4;
  localparam int RATE_W = 2;

  typedef struct packed {
    logic              mclk_on;
    logic              port_on;
    logic [RATE_W-1:0] rate;
  } cfg_t;

  // Half bit-clock period in clk cycles: master clock /8, /4, /2 per rate,
  // doubled when the master clock is clk/2. Code 11 behaves like 00.
  function automatic int unsigned half_len(input logic [RATE_W-1:0] rate,
                                           input logic range_hi);
    int unsigned base;
    case (rate)
      2'b01:   base = 2;
      2'b10:   base = 1;
      default: base = 4;
    endcase
    return range_hi ? base * 2 : base;
  endfunction

endpackage

// File: rtl/i2s_dac_clkgen.sv
module i2s_dac_clkgen
  import i2s_dac_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              range_hi,
  input  logic [RATE_W-1:0] rate,
  output logic              half_tick,
  output logic              sclk_q,
  output logic              sclk_fall,
  output logic              mclk_div
);

  logic [DIV_W-1:0] div_cnt;

  assign half_tick = run && (div_cnt == DIV_W'(half_len(rate, range_hi) - 1));
  assign sclk_fall = half_tick && sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      sclk_q   <= 1'b0;
      mclk_div <= 1'b0;
    end else if (!run) begin
      div_cnt  <= '0;
      sclk_q   <= 1'b0;
      mclk_div <= 1'b0;
    end else begin
      mclk_div <= ~mclk_div;
      if (half_tick) begin
        div_cnt <= '0;
        sclk_q  <= ~sclk_q;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2s_dac_serializer.sv
module i2s_dac_serializer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sclk_fall,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_left,
  input  logic [WORD_W-1:0] smp_right,
  output logic              smp_ready,
  output logic              frame_edge,
  output logic              lr_q,
  output logic              sdata_q
);

  localparam int SLOTS = 2 * WORD_W;
  localparam int CNT_W = $clog2(SLOTS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  nxt_slot;
  logic [SLOTS-1:0]  sh;
  logic [WORD_W-1:0] hold_l, hold_r, cur_l, cur_r;
  logic              hold_full;
  logic              take;

  assign smp_ready  = !hold_full;
  assign take       = smp_valid && !hold_full;
  assign frame_edge = sclk_fall && (bit_cnt == LAST);
  assign nxt_slot   = bit_cnt + 1'b1;

  // slot counter, word select and data line all move on falling bit clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= LAST;
      lr_q    <= 1'b1;
      sdata_q <= 1'b0;
    end else if (!run) begin
      bit_cnt <= LAST;
      lr_q    <= 1'b1;
      sdata_q <= 1'b0;
    end else if (sclk_fall) begin
      bit_cnt <= nxt_slot;
      lr_q    <= (nxt_slot >= CNT_W'(WORD_W));
      sdata_q <= sh[SLOTS-1];
    end
  end

  // holding slot, current pair and shift register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      cur_l     <= '0;
      cur_r     <= '0;
      sh        <= '0;
    end else if (frame_edge) begin
      if (hold_full) begin
        cur_l     <= hold_l;
        cur_r     <= hold_r;
        sh        <= {hold_l, hold_r};
        hold_full <= 1'b0;
      end else if (take) begin
        cur_l <= smp_left;
        cur_r <= smp_right;
        sh    <= {smp_left, smp_right};
      end else begin
        sh <= {cur_l, cur_r};
      end
    end else begin
      if (take) begin
        hold_l    <= smp_left;
        hold_r    <= smp_right;
        hold_full <= 1'b1;
      end
      if (!run) sh <= '0;
      else if (sclk_fall) sh <= {sh[SLOTS-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/i2s_dac_port.sv
module i2s_dac_port
  import i2s_dac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int PIN_N  = 4,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_range,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_q,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_left,
  input  logic [WORD_W-1:0] smp_right,
  output logic              smp_ready,
  input  logic [PIN_N-1:0]  gpio_out,
  input  logic [PIN_N-1:0]  gpio_oe,
  output logic [PIN_N-1:0]  pad_out,
  output logic [PIN_N-1:0]  pad_oe
);

  cfg_t              cfg_s;
  logic              act_en;
  logic [RATE_W-1:0] act_rate;
  logic              act_range;
  logic              half_tick, sclk_q, sclk_fall, mclk_div;
  logic              frame_edge, lr_q, sdata_q;
  logic              mclk_pin;
  logic              apply_now;

  assign cfg_s     = cfg_t'(cfg_q);
  assign apply_now = !act_en || frame_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  // settings that shape a frame are only taken over at a frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en    <= 1'b0;
      act_rate  <= '0;
      act_range <= 1'b0;
    end else if (apply_now) begin
      act_en    <= cfg_s.port_on;
      act_rate  <= cfg_s.rate;
      act_range <= clk_range;
    end
  end

  i2s_dac_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (act_en),
    .range_hi  (act_range),
    .rate      (act_rate),
    .half_tick (half_tick),
    .sclk_q    (sclk_q),
    .sclk_fall (sclk_fall),
    .mclk_div  (mclk_div)
  );

  i2s_dac_serializer #(.WORD_W(WORD_W)) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (act_en),
    .sclk_fall  (sclk_fall),
    .smp_valid  (smp_valid),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .smp_ready  (smp_ready),
    .frame_edge (frame_edge),
    .lr_q       (lr_q),
    .sdata_q    (sdata_q)
  );

  assign mclk_pin = act_en && cfg_s.mclk_on && (act_range ? mclk_div : clk);

  always_comb begin
    if (act_en) begin
      pad_out = {sdata_q, lr_q, sclk_q, mclk_pin};
      pad_oe  = '1;
    end else begin
      pad_out = gpio_out;
      pad_oe  = gpio_oe;
    end
  end

endmodule

// File: rtl/i2s_dac_port_chk.sv
module i2s_dac_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cfg_q,
  input logic [3:0] pad_out,
  input logic       smp_ready,
  input logic       act_en,
  input logic [1:0] act_rate,
  input logic       frame_edge,
  input logic       half_tick
);

  // R6
  lr_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && $past(act_en) && (pad_out[2] != $past(pad_out[2]))) |-> $fell(pad_out[1]));

  // R6
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && $past(act_en) && (pad_out[3] != $past(pad_out[3]))) |-> $fell(pad_out[1]));

  // R6
  slot0_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_edge && cfg_q[2]) |=> (!pad_out[1] && !pad_out[2]));

  // R5
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && !half_tick) |=> $stable(pad_out[1]));

  // R7
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_ready && !frame_edge) |=> !smp_ready);

  // R9
  cfg_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && !frame_edge) |=> (act_en && $stable(act_rate)));

  // R4
  mclk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && !cfg_q[3]) |-> !pad_out[0]);

endmodule

bind i2s_dac_port i2s_dac_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_q      (cfg_q),
  .pad_out    (pad_out),
  .smp_ready  (smp_ready),
  .act_en     (act_en),
  .act_rate   (act_rate),
  .frame_edge (frame_edge),
  .half_tick  (half_tick)
);

// File: tb/sim_i2s_dac_port.sv
module sim_i2s_dac_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_range = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic [3:0]  cfg_q;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_left = '0, smp_right = '0;
  logic        smp_ready;
  logic [3:0]  gpio_out = '0, gpio_oe = '0;
  logic [3:0]  pad_out, pad_oe;

  always #10 clk = ~clk;

  i2s_dac_port u0 (
    .clk(clk), .rst_n(rst_n), .clk_range(clk_range),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .smp_ready(smp_ready), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // receiver model: samples data and word select on rising bit clock
  int          cyc = 0, last_rise = 0, rise_cnt = 0, frm_cnt = 0;
  int          cur_bnd = 0, exp_h = 4;
  int          iv_log [0:63];
  int          bnd_log [0:15];
  logic [31:0] frame_log [0:15];
  logic [31:0] cap = '0;
  logic        sclk_p = 1'b0, lr_at_rise = 1'b0;
  bit          have_start = 0;

  always @(negedge clk) begin
    cyc++;
    if (pad_out[1] && !sclk_p) begin
      iv_log[rise_cnt % 64] = cyc - last_rise;
      last_rise = cyc;
      rise_cnt++;
      cap = {cap[30:0], pad_out[3]};
      if (!pad_out[2] && lr_at_rise) begin
        if (have_start) begin
          frame_log[frm_cnt % 16] = cap;
          bnd_log[frm_cnt % 16]   = cur_bnd;
          frm_cnt++;
        end
        have_start = 1;
        cur_bnd = cyc - exp_h;
      end
      lr_at_rise = pad_out[2];
    end
    sclk_p = pad_out[1];
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int t;
    t = frm_cnt;
    while (frm_cnt < t + n) step();
  endtask

  task automatic push(input logic [15:0] l, input logic [15:0] r);
    while (!smp_ready) step();
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    step();
    smp_valid = 1'b0;
  endtask

  task automatic t_reset();
    gpio_out = 4'b1010; gpio_oe = 4'b0110;
    step();
    chk(cfg_q == 4'h0, "R1 cfg reset", cfg_q, 0);
    chk(smp_ready == 1'b1, "R1 ready after reset", smp_ready, 1);
    chk(pad_out == gpio_out && pad_oe == gpio_oe, "R1 R3 gpio after reset",
        {pad_oe, pad_out}, {gpio_oe, gpio_out});
    gpio_out = 4'b0101; gpio_oe = 4'b1001;
    step();
    chk(pad_out == 4'b0101 && pad_oe == 4'b1001, "R3 gpio follows", {pad_oe, pad_out}, 8'h95);
  endtask

  task automatic t_cfg_write();
    wr_cfg(4'b1011);
    chk(cfg_q == 4'b1011, "R2 cfg readback", cfg_q, 4'hB);
    repeat (20) step();
    chk(pad_oe == gpio_oe && pad_out == gpio_out, "R3 port bit clear keeps gpio",
        {pad_oe, pad_out}, {gpio_oe, gpio_out});
    wr_cfg(4'b0000);
    chk(cfg_q == 4'b0000, "R2 cfg cleared", cfg_q, 0);
    gpio_out = '0; gpio_oe = '0;
  endtask

  task automatic t_data();
    int base;
    bit mclk_hi;
    base = frm_cnt;
    push(16'hA5C3, 16'h0F1E);
    have_start = 0; exp_h = 4; clk_range = 1'b0;
    wr_cfg(4'b0100);
    step();
    chk(pad_oe == 4'hF, "R3 port drives all pins", pad_oe, 4'hF);
    push(16'h8001, 16'h7FFE);
    push(16'h1234, 16'hFEDC);
    while (frm_cnt < base + 4) step();
    chk(frame_log[base % 16] == 32'hA5C30F1E, "R6 frame 1 left then right",
        frame_log[base % 16], 32'hA5C30F1E);
    chk(frame_log[(base + 1) % 16] == 32'h80017FFE, "R6 R7 frame 2",
        frame_log[(base + 1) % 16], 32'h80017FFE);
    chk(frame_log[(base + 2) % 16] == 32'h1234FEDC, "R7 frame 3",
        frame_log[(base + 2) % 16], 32'h1234FEDC);
    chk(frame_log[(base + 3) % 16] == 32'h1234FEDC, "R8 repeat without sample",
        frame_log[(base + 3) % 16], 32'h1234FEDC);
    chk(iv_log[(rise_cnt - 1) % 64] == 8, "R5 period rate 00",
        iv_log[(rise_cnt - 1) % 64], 8);
    mclk_hi = 0;
    for (int k = 0; k < 16; k++) begin
      @(posedge clk); #1;
      if (pad_out[0]) mclk_hi = 1;
    end
    step();
    chk(!mclk_hi, "R4 master clock gated off", mclk_hi, 0);
  endtask

  task automatic t_rate(input logic [1:0] rate, input logic rng, input int period);
    int  hi;
    logic a, b;
    clk_range = rng;
    exp_h = period / 2;
    wr_cfg({2'b11, rate});
    wait_frames(2);
    chk(iv_log[(rise_cnt - 1) % 64] == period, $sformatf("R5 period rate %0d range %0d", rate, rng),
        iv_log[(rise_cnt - 1) % 64], period);
    chk(frame_log[(frm_cnt - 1) % 16] == 32'h1234FEDC, "R6 R8 data at this rate",
        frame_log[(frm_cnt - 1) % 16], 32'h1234FEDC);
    if (rng) begin
      step(); a = pad_out[0];
      step(); b = pad_out[0];
      chk(a != b, "R4 master clock halved toggles", b, !a);
    end else begin
      hi = 0;
      for (int k = 0; k < 4; k++) begin
        @(posedge clk); #1;
        if (pad_out[0]) hi++;
      end
      step();
      chk(hi == 4, "R4 master clock follows clk", hi, 4);
    end
  endtask

  task automatic t_midframe();
    int rc0, bad;
    clk_range = 1'b0; exp_h = 4;
    wr_cfg(4'b0100);
    wait_frames(2);
    wait_frames(1);
    rc0 = rise_cnt;
    wr_cfg(4'b0110);
    exp_h = 1;
    while (rise_cnt < rc0 + 34) step();
    bad = 0;
    for (int k = 0; k < 31; k++) if (iv_log[(rc0 + k) % 64] != 8) bad++;
    chk(bad == 0, "R9 rest of frame keeps old period", bad, 0);
    chk(iv_log[(rc0 + 32) % 64] == 2, "R9 next frame uses new period",
        iv_log[(rc0 + 32) % 64], 2);
    wait_frames(1);
    wr_cfg(4'b0010);
    step();
    chk(pad_oe == 4'hF, "R9 disable waits for boundary", pad_oe, 4'hF);
    repeat (80) step();
    chk(pad_oe == gpio_oe && pad_out == gpio_out, "R3 R9 gpio after boundary",
        {pad_oe, pad_out}, {gpio_oe, gpio_out});
  endtask

  task automatic t_coincide();
    int b1, a, bexp, fb, t, guard;
    logic [31:0] prev, nw, fw;
    bit got;
    prev = 32'h1234FEDC;
    clk_range = 1'b0; exp_h = 4; have_start = 0;
    wr_cfg(4'b0100);
    wait_frames(2);
    for (int d = -3; d <= 2; d++) begin
      wait_frames(1);
      b1 = cur_bnd + 256;
      a  = b1 + d;
      nw = {16'hC000 | 16'(d + 8), 16'h00F0 | 16'(d + 8)};
      while (cyc < a - 1) step();
      chk(smp_ready == 1'b1, "R7 slot empty before push", smp_ready, 1);
      smp_valid = 1'b1; smp_left = nw[31:16]; smp_right = nw[15:0];
      step();
      smp_valid = 1'b0;
      bexp = (cyc <= b1) ? b1 : b1 + 256;
      got = 0; guard = 0;
      while (!got && guard < 6) begin
        t = frm_cnt;
        while (frm_cnt == t) step();
        fb = bnd_log[(frm_cnt - 1) % 16];
        fw = frame_log[(frm_cnt - 1) % 16];
        if (fb < bexp) chk(fw == prev, "R7 R8 earlier frame keeps old pair", fw, prev);
        else begin
          chk(fw == nw, $sformatf("R7 pair at boundary offset %0d", d), fw, nw);
          got = 1;
        end
        guard++;
      end
      chk(got, "R7 pair reached a frame", got, 1);
      prev = nw;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cfg_write();
    t_data();
    t_rate(2'b01, 1'b0, 4);
    t_rate(2'b10, 1'b0, 2);
    t_rate(2'b11, 1'b0, 8);
    t_rate(2'b00, 1'b1, 16);
    t_rate(2'b10, 1'b1, 4);
    t_midframe();
    t_coincide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule